// File: doc/BRIEF.md
# Segment-Cached Row Buffer Controller

This block controls a memory front end in which every column read and column write goes through a small set of row-segment buffers. The bank arrays behind it are never reached directly. The requester manages the buffers explicitly. A fetch command copies one bank row into a segment the requester chooses. A store command copies a segment back to the bank row recorded in its tag. Column commands read or modify a single word of a segment that holds valid data.

For each segment the controller keeps a tag: a valid bit, the source bank, the source row and a dirty bit. It also runs a fixed-length transfer sequencer that moves a whole row between a bank and a segment in one timed operation. The two banks are behavioural memories. Hardware never picks a segment or evicts one; placement is left entirely to the requester.

Top module: `segbuf_top`

## Requirements
- R1: After reset, `busy`, `rd_valid`, `err` and `rd_dirty` are 0, and every segment is invalid.
- R2: A read (`cmd_op`=2'b00) accepted while `busy` is low, to a valid segment, gives `rd_valid`=1 for one cycle after the accepting edge. In that cycle `rd_data` holds the addressed word and `rd_dirty` holds the segment's dirty bit.
- R3: A write (`cmd_op`=2'b01) to a valid segment replaces the addressed word and sets the segment's dirty bit.
- R4: A read or write to an invalid segment pulses `err` for one cycle, leaves `rd_valid` at 0 and changes no data.
- R5: A fetch (`cmd_op`=2'b10) holds `busy` high for exactly XFER_CYCLES (default 3) cycles. After that the segment holds the addressed bank row, its tag is valid and its dirty bit is clear.
- R6: A store (`cmd_op`=2'b11) to a valid segment holds `busy` for XFER_CYCLES cycles, writes the segment into the bank row named by its tag and clears the dirty bit. A store to an invalid segment pulses `err` and starts no transfer.
- R7: Commands presented while `busy` is high are ignored: they produce no response, no error and no data change.
- R8: Bank contents change only through a store. Bank 0 and bank 1 keep separate rows, so a fetch after a write that was never stored returns the old bank data.
- R9: After reset, word c of row r of bank b holds 32'hB000_0000 | b<<16 | r<<8 | c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 00 read, 01 write, 10 fetch, 11 store |
| cmd_seg | input | 4 | Target segment |
| cmd_bank | input | 1 | Bank for fetch |
| cmd_row | input | 3 | Row for fetch |
| cmd_col | input | 6 | Word within segment |
| cmd_wdata | input | 32 | Write data |
| busy | output | 1 | Row transfer in progress |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read data |
| rd_dirty | output | 1 | Dirty bit of the segment that was read |
| err | output | 1 | Command addressed an invalid segment |

## Verification
Read responses, error pulses and write effects all take effect on the edge that accepts the command. The bench therefore drives each command at a falling edge and samples the outputs at the very next falling edge. For fetch and store it then counts the falling edges at which `busy` is still high and expects exactly three of them. A read is issued only after `busy` has dropped, which is when the moved row is ready to read. The test for ignored commands presents a write during the second busy cycle. It confirms at the next falling edge that nothing responded, and a later read shows that the word is unchanged.

// File: rtl/segbuf_pkg.sv
package segbuf_pkg;
    localparam int NUM_SEG  = 16;
    localparam int SEG_BITS = 2048;
    localparam int WORD_W   = 32;
    localparam int NUM_BANK = 2;
    localparam int ROWS     = 8;
    localparam int WORDS    = SEG_BITS / WORD_W;
    localparam int COL_W    = $clog2(WORDS);
    localparam int SEG_W    = $clog2(NUM_SEG);
    localparam int ROW_W    = $clog2(ROWS);
    localparam int BANK_W   = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_FETCH = 2'b10,
        OP_STORE = 2'b11
    } op_e;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
    } tag_t;

    typedef struct packed {
        logic              to_bank;
        logic [SEG_W-1:0]  seg;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
    } xfer_t;

    function automatic logic [WORD_W-1:0] init_word(int b, int r, int c);
        logic [WORD_W-1:0] w;
        w = 32'hB000_0000;
        w = w | (WORD_W'(b) << 16) | (WORD_W'(r) << 8) | WORD_W'(c);
        return w;
    endfunction
endpackage

// File: rtl/segbuf_tags.sv
module segbuf_tags
    import segbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEG_W-1:0] look_seg,
    output tag_t             look_tag,
    input  logic             mark_dirty,
    input  logic             xfer_done,
    input  xfer_t            xfer_info
);
    tag_t tags [NUM_SEG];

    assign look_tag = tags[look_seg];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SEG; s++) begin
                tags[s] <= '0;
            end
        end else begin
            if (mark_dirty) begin
                tags[look_seg].dirty <= 1'b1;
            end
            if (xfer_done) begin
                if (xfer_info.to_bank) begin
                    tags[xfer_info.seg].dirty <= 1'b0;
                end else begin
                    tags[xfer_info.seg] <= '{valid: 1'b1, dirty: 1'b0,
                                            bank: xfer_info.bank,
                                            row: xfer_info.row};
                end
            end
        end
    end
endmodule

// File: rtl/segbuf_xfer_seq.sv
module segbuf_xfer_seq
    import segbuf_pkg::*;
#(
    parameter int XFER_CYCLES = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  xfer_t req,
    output logic  busy,
    output logic  done,
    output xfer_t cur
);
    localparam int CNT_W = $clog2(XFER_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    assign busy = (remain != '0);
    assign done = (remain == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
            cur    <= '0;
        end else if (start && !busy) begin
            remain <= CNT_W'(XFER_CYCLES);
            cur    <= req;
        end else if (busy) begin
            remain <= remain - CNT_W'(1);
        end
    end
endmodule

// File: rtl/segbuf_datapath.sv
module segbuf_datapath
    import segbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEG_W-1:0]  seg,
    input  logic [COL_W-1:0]  col,
    input  logic              col_wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              xfer_go,
    input  xfer_t             xfer_info
);
    logic [WORD_W-1:0] seg_mem  [NUM_SEG][WORDS];
    logic [WORD_W-1:0] bank_mem [NUM_BANK][ROWS][WORDS];

    assign rdata = seg_mem[seg][col];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NUM_BANK; b++) begin
                for (int r = 0; r < ROWS; r++) begin
                    for (int c = 0; c < WORDS; c++) begin
                        bank_mem[b][r][c] <= init_word(b, r, c);
                    end
                end
            end
        end else begin
            if (xfer_go) begin
                for (int c = 0; c < WORDS; c++) begin
                    if (xfer_info.to_bank) begin
                        bank_mem[xfer_info.bank][xfer_info.row][c] <= seg_mem[xfer_info.seg][c];
                    end else begin
                        seg_mem[xfer_info.seg][c] <= bank_mem[xfer_info.bank][xfer_info.row][c];
                    end
                end
            end
            if (col_wr) begin
                seg_mem[seg][col] <= wdata;
            end
        end
    end
endmodule

// File: rtl/segbuf_top.sv
module segbuf_top
    import segbuf_pkg::*;
#(
    parameter int XFER_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [SEG_W-1:0]  cmd_seg,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ROW_W-1:0]  cmd_row,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_dirty,
    output logic              err
);
    op_e               op;
    tag_t              tag;
    logic              accept, do_rd, do_wr, bad, start, done;
    xfer_t             req, cur;
    logic [WORD_W-1:0] seg_word;

    assign op     = op_e'(cmd_op);
    assign accept = cmd_valid && !busy;
    assign do_rd  = accept && (op == OP_READ)  && tag.valid;
    assign do_wr  = accept && (op == OP_WRITE) && tag.valid;
    assign bad    = accept && (op != OP_FETCH) && !tag.valid;
    assign start  = accept && ((op == OP_FETCH) || ((op == OP_STORE) && tag.valid));

    always_comb begin
        req.to_bank = (op == OP_STORE);
        req.seg     = cmd_seg;
        req.bank    = (op == OP_STORE) ? tag.bank : cmd_bank;
        req.row     = (op == OP_STORE) ? tag.row  : cmd_row;
    end

    segbuf_tags u_tags (
        .clk       (clk),
        .rst       (rst),
        .look_seg  (cmd_seg),
        .look_tag  (tag),
        .mark_dirty(do_wr),
        .xfer_done (done),
        .xfer_info (cur)
    );

    segbuf_xfer_seq #(.XFER_CYCLES(XFER_CYCLES)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .req  (req),
        .busy (busy),
        .done (done),
        .cur  (cur)
    );

    segbuf_datapath u_dp (
        .clk      (clk),
        .rst      (rst),
        .seg      (cmd_seg),
        .col      (cmd_col),
        .col_wr   (do_wr),
        .wdata    (cmd_wdata),
        .rdata    (seg_word),
        .xfer_go  (done),
        .xfer_info(cur)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_dirty <= 1'b0;
            err      <= 1'b0;
        end else begin
            rd_valid <= do_rd;
            err      <= bad;
            if (do_rd) begin
                rd_data  <= seg_word;
                rd_dirty <= tag.dirty;
            end
        end
    end
endmodule

// File: rtl/segbuf_checks.sv
module segbuf_checks
    import segbuf_pkg::*;
#(
    parameter int XFER_CYCLES = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       busy,
    input logic       rd_valid,
    input logic       err
);
    logic [7:0] run;

    always_ff @(posedge clk) begin
        if (rst)       run <= '0;
        else if (busy) run <= run + 8'd1;
        else           run <= '0;
    end

    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run == 8'(XFER_CYCLES))); // R5
    AST_FETCH_STARTS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_op == 2'b10) |=> busy); // R5
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        err |-> !rd_valid); // R4
    AST_RD_FROM_READ: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(cmd_valid && !busy && cmd_op == 2'b00)); // R2
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> (!rd_valid && !err)); // R7
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        err |=> !err || $past(cmd_valid && !busy)); // R4
endmodule

bind segbuf_top segbuf_checks #(.XFER_CYCLES(XFER_CYCLES)) u_checks (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .rd_valid(rd_valid), .err(err)
);

// File: tb/test_segbuf_top.sv
`timescale 1ns/1ps
module test_segbuf_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [3:0]  cmd_seg;
    logic [0:0]  cmd_bank;
    logic [2:0]  cmd_row;
    logic [5:0]  cmd_col;
    logic [31:0] cmd_wdata;
    logic        busy, rd_valid, rd_dirty, err;
    logic [31:0] rd_data;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    segbuf_top i_segbuf_top (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_seg(cmd_seg), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .cmd_wdata(cmd_wdata), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_dirty(rd_dirty), .err(err)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  seg;
        logic        bank;
        logic [2:0]  row;
        logic [5:0]  col;
        logic [31:0] wdata;
        logic        e_err;
        logic        e_rv;
        logic [31:0] e_data;
        logic        e_dirty;
        logic [3:0]  e_busy;
        logic [3:0]  req;
    } vec_t;

    function automatic logic [31:0] pat(int b, int r, int c);
        return 32'hB000_0000 + b * 32'h1_0000 + r * 32'h100 + c;
    endfunction

    function automatic vec_t mk(logic [1:0] op, int seg, int bank, int row, int col,
                                logic [31:0] wd, logic ee, logic erv, logic [31:0] ed,
                                logic edt, int eb, int rq);
        vec_t v;
        v.op = op; v.seg = 4'(seg); v.bank = 1'(bank); v.row = 3'(row);
        v.col = 6'(col); v.wdata = wd; v.e_err = ee; v.e_rv = erv;
        v.e_data = ed; v.e_dirty = edt; v.e_busy = 4'(eb); v.req = 4'(rq);
        return v;
    endfunction

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        mk(2'b00, 2, 0, 0, 3, 0,            1, 0, 0,            0, 0, 4),  // R4 read invalid
        mk(2'b01, 2, 0, 0, 3, 32'h0BAD_0BAD, 1, 0, 0,           0, 0, 4),  // R4 write invalid
        mk(2'b10, 2, 0, 5, 0, 0,            0, 0, 0,            0, 3, 5),  // R5 fetch
        mk(2'b00, 2, 0, 0, 7, 0,            0, 1, pat(0,5,7),   0, 0, 9),  // R9 init pattern
        mk(2'b01, 2, 0, 0, 7, 32'h1234_5678, 0, 0, 0,           0, 0, 3),  // R3 write
        mk(2'b00, 2, 0, 0, 7, 0,            0, 1, 32'h1234_5678, 1, 0, 3), // R3 dirty set
        mk(2'b10, 3, 1, 5, 0, 0,            0, 0, 0,            0, 3, 5),  // R5 fetch bank 1
        mk(2'b00, 3, 0, 0, 7, 0,            0, 1, pat(1,5,7),   0, 0, 8),  // R8 bank separation
        mk(2'b11, 2, 0, 0, 0, 0,            0, 0, 0,            0, 3, 6),  // R6 store
        mk(2'b00, 2, 0, 0, 7, 0,            0, 1, 32'h1234_5678, 0, 0, 6), // R6 dirty cleared
        mk(2'b10, 4, 0, 5, 0, 0,            0, 0, 0,            0, 3, 5),  // R5 refetch
        mk(2'b00, 4, 0, 0, 7, 0,            0, 1, 32'h1234_5678, 0, 0, 6), // R6 bank written
        mk(2'b00, 4, 0, 0, 6, 0,            0, 1, pat(0,5,6),   0, 0, 2),  // R2 other word
        mk(2'b11, 9, 0, 0, 0, 0,            1, 0, 0,            0, 0, 6),  // R6 store invalid
        mk(2'b01, 3, 0, 0, 0, 32'hAAAA_5555, 0, 0, 0,           0, 0, 3),  // R3 write seg3
        mk(2'b10, 3, 1, 5, 0, 0,            0, 0, 0,            0, 3, 8),  // R8 refetch unstored
        mk(2'b00, 3, 0, 0, 0, 0,            0, 1, pat(1,5,0),   0, 0, 8)   // R8 old data
    };

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic issue(logic [1:0] op, logic [3:0] seg, logic bank, logic [2:0] row,
                         logic [5:0] col, logic [31:0] wd);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_seg = seg; cmd_bank = bank;
        cmd_row = row; cmd_col = col; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 20) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        string rq;
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_seg = '0;
        cmd_bank = '0; cmd_row = '0; cmd_col = '0; cmd_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 rd_valid", 32'(rd_valid), 0);
        chk("R1 err", 32'(err), 0);
        chk("R1 rd_dirty", 32'(rd_dirty), 0);

        for (int i = 0; i < NV; i++) begin
            rq = $sformatf("R%0d vec%0d", VEC[i].req, i);
            issue(VEC[i].op, VEC[i].seg, VEC[i].bank, VEC[i].row, VEC[i].col, VEC[i].wdata);
            chk({rq, " err"}, 32'(err), 32'(VEC[i].e_err));
            chk({rq, " rd_valid"}, 32'(rd_valid), 32'(VEC[i].e_rv));
            if (VEC[i].e_rv) begin
                chk({rq, " rd_data"}, rd_data, VEC[i].e_data);
                chk({rq, " rd_dirty"}, 32'(rd_dirty), 32'(VEC[i].e_dirty));
            end
            wait_idle(n);
            chk({rq, " busy cycles"}, 32'(n), 32'(VEC[i].e_busy));
        end

        // R7: write presented during a fetch is ignored
        issue(2'b10, 4'd6, 1'b0, 3'd2, 6'd0, 32'h0);
        chk("R7 busy after fetch", 32'(busy), 1);
        issue(2'b01, 4'd2, 1'b0, 3'd0, 6'd7, 32'hDEAD_BEEF);
        chk("R7 no err while busy", 32'(err), 0);
        chk("R7 no rd_valid while busy", 32'(rd_valid), 0);
        wait_idle(n);
        issue(2'b00, 4'd2, 1'b0, 3'd0, 6'd7, 32'h0);
        chk("R7 word unchanged", rd_data, 32'h1234_5678);
        chk("R7 dirty unchanged", 32'(rd_dirty), 0);
        issue(2'b00, 4'd6, 1'b0, 3'd0, 6'd63, 32'h0);
        chk("R9 last word", rd_data, pat(0, 2, 63));

        // R1: reset clears tags
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 busy after reset", 32'(busy), 0);
        issue(2'b00, 4'd2, 1'b0, 3'd0, 6'd7, 32'h0);
        chk("R1 segment invalid", 32'(err), 1);
        chk("R1 no read data", 32'(rd_valid), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule